// File: doc/BRIEF.md
# Multi-converter alignment trigger detector

This block sits on the receive side of a system with several data converters. Each converter delivers one stream, made of a sample and a strobe that marks a valid sample. A common SYNC pulse restarts every converter. When the pulse falls, the block arms a detector on each stream and waits for that stream's timing marker.

The marker can come from one of three sources. The first is the wrap of the converter's test ramp from its highest code back to zero. The second is the single all-ones sample of the flashing test pattern. The third is the first strobe edge after the SYNC pulse ends.

Each stream counts clock cycles from SYNC release to its own marker, emits a one-cycle trigger and freezes its count. The block reports each stream's latency difference against a reference stream, and it flags streams whose marker never came. It asserts an aligned flag once two measurements in a row show every difference at zero. Repeating SYNC pulses start a new measurement each time.

Top module: `conv_align_detect`

## Requirements
- R1: After reset, and before any SYNC release, `trig_o`, `done_o`, `timeout_o` and `aligned_o` are all 0, every `offset_o` field is 0, and strobe activity produces no trigger.
- R2: While `sync_i` is 1, all per-stream measurement state is cleared, so `done_o` reads 0 one cycle later. The clock edge at which `sync_i` is sampled 0 after being 1 arms every stream, and each further pulse re-arms them.
- R3: In ramp mode (`mode_i`=0), a stream's marker is a valid sample equal to 0 whose previous valid sample since release was the all-ones code.
- R4: In flash mode (`mode_i`=1), a stream's marker is a valid all-ones sample preceded by exactly P consecutive valid zero samples since release. P is 10, 11 or 15 for `flash_sel_i` = 0, 1 or 2/3.
- R5: In flash mode, an all-ones sample preceded by a zero run of any length other than P is ignored, and it restarts the zero count.
- R6: In ready mode (`mode_i`=2 or 3), a stream's marker is the first 0-to-1 transition of its `valid_i` bit after release.
- R7: For each stream, `trig_o` rises in the cycle after the marker sample is clocked in, stays high for exactly one cycle, and fires at most once per arming.
- R8: A stream's latency is the number of valid-or-idle cycles from the first clock after release to its marker. `offset_o[i]` is the signed value latency(i) minus latency(REF_IDX), and it is valid once `done_o` is all ones.
- R9: If no marker arrives within MAX_LAT cycles of release, the stream sets `timeout_o` and `done_o` and never triggers in that arming.
- R10: `aligned_o` becomes 1 after two consecutive completed measurements with every offset 0 and no timeout. It becomes 0 after a completed measurement with a nonzero offset or a timeout, and it is not changed by SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Common SYNC pulse, active high |
| mode_i | input | 2 | Marker source: 0 ramp, 1 flash, 2/3 ready edge |
| flash_sel_i | input | 2 | Flash zero run: 0→10, 1→11, 2/3→15 |
| valid_i | input | N_STREAMS | Per-stream sample strobe |
| sample_i | input | N_STREAMS*SAMPLE_W | Per-stream samples, stream i at bits [i*SAMPLE_W +: SAMPLE_W] |
| trig_o | output | N_STREAMS | One-cycle marker trigger per stream |
| done_o | output | N_STREAMS | Stream has triggered or timed out |
| timeout_o | output | N_STREAMS | Stream found no marker in MAX_LAT cycles |
| offset_o | output | N_STREAMS*(CNT_W+1) | Signed latency difference to reference, stream i at [i*(CNT_W+1) +: CNT_W+1] |
| aligned_o | output | 1 | Two consecutive all-zero measurements |

## Verification
The hardest situation to reach is a flash marker that is rejected even though it lands on the true pattern slot. This happens when a stray all-ones sample in the middle of a zero run cuts the run short, so the next genuine marker is skipped and the stream locks one full period later. The stimulus injects a single spurious all-ones sample into one stream between two flash markers and expects that stream's offset to grow by exactly P+1. The aligned flag's two-measurement memory is reached by chaining SYNC pulses, so equal-latency runs follow each other and a timeout run then breaks the chain.

// File: rtl/conv_align_pkg.sv
package conv_align_pkg;
  typedef enum logic [1:0] {
    MK_RAMP   = 2'd0,
    MK_FLASH  = 2'd1,
    MK_READY  = 2'd2,
    MK_READY2 = 2'd3
  } marker_e;

  function automatic logic [4:0] flash_zero_run(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd10;
      2'd1:    return 5'd11;
      default: return 5'd15;
    endcase
  endfunction
endpackage

// File: rtl/stream_marker.sv
module stream_marker
  import conv_align_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  marker_e             mode_i,
  input  logic [1:0]          flash_sel_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                hit_o
);
  logic [SAMPLE_W-1:0] prev_q;
  logic                prev_ok_q;
  logic [4:0]          zrun_q;
  logic                vld_q;
  logic                is_full, is_zero, prev_full;

  assign is_full   = &sample_i;
  assign is_zero   = (sample_i == '0);
  assign prev_full = prev_ok_q && (&prev_q);

  always_comb begin
    case (mode_i)
      MK_RAMP:  hit_o = valid_i && prev_full && is_zero;
      MK_FLASH: hit_o = valid_i && is_full && (zrun_q == flash_zero_run(flash_sel_i));
      default:  hit_o = valid_i && !vld_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      zrun_q    <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (sync_i) begin
        prev_ok_q <= 1'b0;
        zrun_q    <= '0;
      end else if (valid_i) begin
        prev_q    <= sample_i;
        prev_ok_q <= 1'b1;
        if (!is_zero)          zrun_q <= '0;
        else if (zrun_q != '1) zrun_q <= zrun_q + 5'd1;
      end
    end
  end
endmodule

// File: rtl/lat_counter.sv
module lat_counter #(
  parameter int MAX_LAT = 255,
  parameter int CNT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             release_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] lat_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             trig_o
);
  localparam logic [CNT_W-1:0] MaxC = CNT_W'(MAX_LAT);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      lat_o     <= '0;
      armed_q   <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      trig_o    <= 1'b0;
    end else if (sync_i) begin
      cnt_q     <= '0;
      lat_o     <= '0;
      armed_q   <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      trig_o    <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (release_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && !done_o) begin
        if (hit_i) begin
          lat_o  <= cnt_q;
          done_o <= 1'b1;
          trig_o <= 1'b1;
        end else if (cnt_q == MaxC) begin
          lat_o     <= cnt_q;
          done_o    <= 1'b1;
          timeout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/align_eval.sv
module align_eval (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_all_i,
  input  logic any_timeout_i,
  input  logic all_zero_i,
  output logic aligned_o
);
  logic       done_q;
  logic [1:0] streak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      streak_q <= '0;
    end else begin
      done_q <= done_all_i;
      if (done_all_i && !done_q) begin
        if (all_zero_i && !any_timeout_i)
          streak_q <= (streak_q == 2'd2) ? 2'd2 : streak_q + 2'd1;
        else
          streak_q <= '0;
      end
    end
  end

  assign aligned_o = (streak_q == 2'd2);
endmodule

// File: rtl/conv_align_detect.sv
module conv_align_detect
  import conv_align_pkg::*;
#(
  parameter int N_STREAMS = 4,
  parameter int SAMPLE_W  = 10,
  parameter int REF_IDX   = 0,
  parameter int MAX_LAT   = 255,
  parameter int CNT_W     = $clog2(MAX_LAT + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sync_i,
  input  logic [1:0]                      mode_i,
  input  logic [1:0]                      flash_sel_i,
  input  logic [N_STREAMS-1:0]            valid_i,
  input  logic [N_STREAMS*SAMPLE_W-1:0]   sample_i,
  output logic [N_STREAMS-1:0]            trig_o,
  output logic [N_STREAMS-1:0]            done_o,
  output logic [N_STREAMS-1:0]            timeout_o,
  output logic [N_STREAMS*(CNT_W+1)-1:0]  offset_o,
  output logic                            aligned_o
);
  localparam int OW = CNT_W + 1;

  logic                 sync_q;
  logic                 release_w;
  logic [N_STREAMS-1:0] hit_w;
  logic [N_STREAMS-1:0] same_w;
  logic [CNT_W-1:0]     lat_w [N_STREAMS];
  marker_e              mode_w;

  assign mode_w    = marker_e'(mode_i);
  assign release_w = sync_q && !sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  for (genvar i = 0; i < N_STREAMS; i++) begin : g_stream
    stream_marker #(.SAMPLE_W(SAMPLE_W)) i_marker (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sync_i      (sync_i),
      .mode_i      (mode_w),
      .flash_sel_i (flash_sel_i),
      .valid_i     (valid_i[i]),
      .sample_i    (sample_i[i*SAMPLE_W +: SAMPLE_W]),
      .hit_o       (hit_w[i])
    );

    lat_counter #(.MAX_LAT(MAX_LAT), .CNT_W(CNT_W)) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sync_i    (sync_i),
      .release_i (release_w),
      .hit_i     (hit_w[i]),
      .lat_o     (lat_w[i]),
      .done_o    (done_o[i]),
      .timeout_o (timeout_o[i]),
      .trig_o    (trig_o[i])
    );

    assign offset_o[i*OW +: OW] = {1'b0, lat_w[i]} - {1'b0, lat_w[REF_IDX]};
    assign same_w[i]            = (lat_w[i] == lat_w[REF_IDX]);
  end

  align_eval i_eval (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_all_i    (&done_o),
    .any_timeout_i (|timeout_o),
    .all_zero_i    (&same_w),
    .aligned_o     (aligned_o)
  );
endmodule

// File: rtl/conv_align_detect_chk.sv
module conv_align_detect_chk #(
  parameter int N_STREAMS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sync_i,
  input logic [N_STREAMS-1:0] trig_o,
  input logic [N_STREAMS-1:0] done_o,
  input logic [N_STREAMS-1:0] timeout_o,
  input logic                 aligned_o
);
  for (genvar i = 0; i < N_STREAMS; i++) begin : g_chk
    a_r7_trig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o[i] |=> !trig_o[i]);
    a_r7_trig_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o[i] |-> done_o[i]);
    a_r2_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_i |=> !done_o[i]);
    a_r9_timeout_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o[i] |-> (done_o[i] && !trig_o[i]));
  end

  a_r10_aligned_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> ((&done_o) && !(|timeout_o)));
endmodule

bind conv_align_detect conv_align_detect_chk #(.N_STREAMS(N_STREAMS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .trig_o    (trig_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .aligned_o (aligned_o)
);

// File: tb/test_conv_align_detect.sv
module test_conv_align_detect;
  localparam int CLK_P   = 10;
  localparam int NS      = 4;
  localparam int SW      = 10;
  localparam int MAX_LAT = 40;
  localparam int CW      = $clog2(MAX_LAT + 1);
  localparam int OW      = CW + 1;
  localparam int RUN     = 60;
  localparam int N_CASE  = 12;

  // mode: 0 ramp, 1 flash, 2 ready; delay 99 = never
  localparam int TAB_MODE [N_CASE] = '{2, 2, 2, 0, 0, 0, 1, 1, 1, 2, 1, 1};
  localparam int TAB_SEL  [N_CASE] = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 2, 0};
  localparam int TAB_D    [N_CASE][NS] = '{
    '{2, 2, 2, 2}, '{2, 2, 2, 2}, '{1, 4, 2, 7},
    '{3, 3, 3, 3}, '{3, 3, 3, 3}, '{5, 0, 9, 3},
    '{1, 3, 0, 5}, '{2, 2, 2, 2}, '{2, 2, 2, 2},
    '{2, 2, 99, 2}, '{4, 1, 6, 2}, '{1, 3, 0, 5}};
  localparam int TAB_GS   [N_CASE] = '{-1, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, 1};
  localparam int TAB_GT   [N_CASE] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sync = 1'b0;
  logic [1:0]         mode = 2'd2;
  logic [1:0]         fsel = 2'd0;
  logic [NS-1:0]      valid = '0;
  logic [NS*SW-1:0]   sample = '0;
  logic [NS-1:0]      trig, done, tmo;
  logic [NS*OW-1:0]   offs;
  logic               aligned;

  int n_chk = 0;
  int n_bad = 0;
  int streak = 0;
  int trig_cnt [NS];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  conv_align_detect #(.N_STREAMS(NS), .SAMPLE_W(SW), .REF_IDX(0), .MAX_LAT(MAX_LAT)) i_conv_align_detect (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .mode_i(mode), .flash_sel_i(fsel),
    .valid_i(valid), .sample_i(sample), .trig_o(trig), .done_o(done),
    .timeout_o(tmo), .offset_o(offs), .aligned_o(aligned));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int zrun(input int sel);
    return (sel == 0) ? 10 : (sel == 1) ? 11 : 15;
  endfunction

  task automatic drive(input int md, input int p, input int d [NS], input int t,
                       input int gs, input int gt);
    for (int s = 0; s < NS; s++) begin
      logic [SW-1:0] v;
      logic          vl;
      v  = '0;
      vl = 1'b1;
      if (md == 0) v = SW'(t - d[s] + 1020);
      else if (md == 1) begin
        if ((t >= d[s] && ((t - d[s]) % (p + 1)) == 0) || (s == gs && t == gt)) v = '1;
      end else vl = (t >= d[s]);
      valid[s] = vl;
      sample[s*SW +: SW] = v;
    end
  endtask

  task automatic count_trig();
    for (int s = 0; s < NS; s++) if (trig[s]) trig_cnt[s]++;
  endtask

  task automatic run_case(input int c);
    int p, mk [NS], dd [NS];
    bit allz;
    p = zrun(TAB_SEL[c]);
    for (int s = 0; s < NS; s++) dd[s] = TAB_D[c][s];
    @(negedge clk);
    sync = 1'b1; valid = '0; sample = '0;
    mode = 2'(TAB_MODE[c]); fsel = 2'(TAB_SEL[c]);
    repeat (3) @(negedge clk);
    check("R2 done cleared by sync", int'(done), 0);
    sync = 1'b0;
    for (int s = 0; s < NS; s++) trig_cnt[s] = 0;
    for (int t = 0; t < RUN; t++) begin
      @(negedge clk);
      count_trig();
      drive(TAB_MODE[c], p, dd, t, TAB_GS[c], TAB_GT[c]);
    end
    repeat (3) begin
      @(negedge clk);
      count_trig();
    end
    for (int s = 0; s < NS; s++) begin
      if (dd[s] == 99) mk[s] = 1000;
      else if (TAB_MODE[c] == 2) mk[s] = dd[s];
      else if (TAB_MODE[c] == 0) mk[s] = dd[s] + 4;
      else mk[s] = dd[s] + p + 1 + ((s == TAB_GS[c]) ? p + 1 : 0);
    end
    allz = 1;
    check("R8 all streams done", int'(done), (1 << NS) - 1);
    for (int s = 0; s < NS; s++) begin
      bit to;
      to = (mk[s] > MAX_LAT);
      check("R9 timeout flag", int'(tmo[s]), int'(to));
      check("R7 one trigger per arming", trig_cnt[s], to ? 0 : 1);
      if (!to) begin
        int o;
        o = $signed(offs[s*OW +: OW]);
        if (TAB_MODE[c] == 0) check("R3 ramp offset", o, mk[s] - mk[0]);
        else if (TAB_MODE[c] == 1 && s == TAB_GS[c]) check("R5 flash glitch offset", o, mk[s] - mk[0]);
        else if (TAB_MODE[c] == 1) check("R4 flash offset", o, mk[s] - mk[0]);
        else check("R6 ready offset", o, mk[s] - mk[0]);
        if (o != 0) allz = 0;
      end else allz = 0;
    end
    streak = allz ? ((streak == 2) ? 2 : streak + 1) : 0;
    check("R10 aligned", int'(aligned), int'(streak == 2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset trig", int'(trig), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset timeout", int'(tmo), 0);
    check("R1 reset offsets", int'(offs == '0), 1);
    check("R1 reset aligned", int'(aligned), 0);
    valid = '1;
    repeat (3) @(negedge clk);
    check("R1 no trigger before arming", int'(trig) + int'(done), 0);
    valid = '0;
    for (int c = 0; c < N_CASE; c++) run_case(c);
    // R2: sync pulse leaves aligned untouched, then re-arms a fresh measurement
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 sync clears done", int'(done), 0);
    check("R10 aligned kept over sync", int'(aligned), int'(streak == 2));
    sync = 1'b0;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule